// File: doc/BRIEF.md
# Sensor Sample Byte FIFO

This block buffers the bytes of sensor samples so that a host can fetch them later. A producer strobes one byte per clock at each sample-rate event, and a host reaches the buffer through a small register port. Reading the data register removes the oldest byte. Writing the data register appends a byte, just as the producer does. The host can read the number of buffered bytes as a 13-bit value split over two registers. A status bit records an overflow.

A control bit sets what happens when a byte arrives and the buffer is full. In one mode the new byte is discarded. In the other mode the new byte replaces the oldest one, so the buffer always holds the most recent data. A self-clearing flush bit empties the buffer. A read while the buffer is empty returns the byte that was last removed.

Top module: `smpf_top`

## Requirements
- R1: After reset the buffer is empty, the count reads 0, the status and control registers read 0 (overwrite mode), and `bus_rdata` is 0.
- R2: A push happens when `smp_strobe` is high, or when the host writes address 0. If both occur in the same cycle, the producer byte is stored and the host byte is dropped. Bytes leave the buffer in the order they arrived.
- R3: A host read of address 0 on a non-empty buffer returns the oldest byte on `bus_rdata` one cycle later and lowers the count by one.
- R4: A host read of address 0 on an empty buffer returns the byte most recently removed (0 if none has been removed since reset) and changes neither the count nor the contents.
- R5: With control bit 0 (address 3) set to 1, a push that arrives when the buffer is full and no removal happens in the same cycle is discarded. The count stays at DEPTH and the stored bytes are unchanged.
- R6: With control bit 0 cleared, such a push replaces the oldest byte. The count stays at DEPTH and the next read returns the byte that was second oldest.
- R7: Status bit 0 (address 4) is set by any push that arrives when the buffer is full without a removal in the same cycle, in either mode. The bit stays set until a read of address 4, which returns 1 and clears it. If a new overflow occurs in the same cycle as that read, the bit stays set.
- R8: A push and a removal in the same cycle on a full buffer perform the removal first. The oldest byte is returned, the count stays at DEPTH, and no overflow is flagged.
- R9: A read of address 1 returns count[12:8] in the low bits and captures the whole count. A read of address 2 returns bits [7:0] of that captured value.
- R10: Writing address 3 loads the mode from bit 0. Writing 1 to bit 1 empties the buffer one cycle later. Pushes and removals in that clearing cycle are ignored. Bit 1 always reads back as 0.
- R11: A push and a removal in the same cycle on a buffer that is neither empty nor full leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_strobe | input | 1 | Producer push of one byte |
| smp_byte | input | 8 | Producer byte |
| bus_addr | input | 3 | Host register select (0 data, 1 count high, 2 count low, 3 control, 4 status) |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid the cycle after `bus_rd` |

## Verification
Directed sequences fill the buffer to exactly DEPTH in each mode and then push past it. This separates the discard rule, where the oldest byte still comes out first, from the overwrite rule, where the second-oldest byte comes out first. A push and a removal in the same cycle on a full buffer show whether the removal is done first: the count stays at full and no status is raised. Random phases with a bias toward pushes and a bias toward removals walk the count through empty, mid-level and full. Between these the bench mixes in host pushes, empty reads, count snapshots, status reads and flushes, so that the timing of latching, clearing and last-byte replay is compared against a queue model.

// File: rtl/smpf_pkg.sv
package smpf_pkg;

   typedef enum logic [2:0] {
      SEL_DATA   = 3'd0,
      SEL_CNT_HI = 3'd1,
      SEL_CNT_LO = 3'd2,
      SEL_CTRL   = 3'd3,
      SEL_STAT   = 3'd4
   } smpf_sel_e;

   localparam int CTRL_KEEP_BIT  = 0;
   localparam int CTRL_FLUSH_BIT = 1;
   localparam int STAT_OVF_BIT   = 0;

endpackage

// File: rtl/smpf_store.sv
module smpf_store #(
   parameter int DEPTH  = 512,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/smpf_ptrs.sv
module smpf_ptrs #(
   parameter int DEPTH = 512,
   parameter int CNT_W = 13,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop_req,
   input  logic             keep_old,
   output logic             wr_en,
   output logic [AW-1:0]    waddr,
   output logic [AW-1:0]    raddr,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             ovf_evt
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [AW-1:0]    wptr_q, rptr_q, wptr_inc, rptr_inc;
   logic [CNT_W-1:0] cnt_q;
   logic             full, push_ok, pop_ok, adv_rd;

   // pointer wrap: free binary wrap for a power-of-two depth, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wptr_inc = wptr_q + 1'b1;
      assign rptr_inc = rptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign wptr_inc = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_inc = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
   end

   always_comb begin
      full    = (cnt_q == FULL_CNT);
      empty   = (cnt_q == '0);
      push_ok = push & ~flush;
      pop_ok  = pop_req & ~empty & ~flush;
      ovf_evt = push_ok & ~pop_ok & full;
      wr_en   = push_ok & ~(ovf_evt & keep_old);
      adv_rd  = pop_ok | (ovf_evt & ~keep_old);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en)  wptr_q <= wptr_inc;
         if (adv_rd) rptr_q <= rptr_inc;
         if (wr_en && !adv_rd)      cnt_q <= cnt_q + 1'b1;
         else if (adv_rd && !wr_en) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign waddr = wptr_q;
   assign raddr = rptr_q;
   assign count = cnt_q;

   // R5
   keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && keep_old) |=> $stable(count));
   // R6
   overwrite_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !keep_old) |=> (count == FULL_CNT));
   // R6
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));
   // R3
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !empty && !flush && !push) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/smpf_regs.sv
module smpf_regs
   import smpf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              empty,
   input  logic [DATA_W-1:0] head_byte,
   input  logic              ovf_evt,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              keep_old,
   output logic              flush,
   output logic              host_push,
   output logic              pop_req
);

   smpf_sel_e         sel;
   logic              flush_q, keep_q, ovf_q;
   logic [CNT_W-1:0]  snap_q;
   logic [DATA_W-1:0] last_q, rdata_q, rd_mux;
   logic              rd_data, rd_hi, rd_stat, wr_ctrl, took;

   always_comb begin
      sel       = smpf_sel_e'(bus_addr);
      rd_data   = bus_rd & (sel == SEL_DATA);
      rd_hi     = bus_rd & (sel == SEL_CNT_HI);
      rd_stat   = bus_rd & (sel == SEL_STAT);
      wr_ctrl   = bus_wr & (sel == SEL_CTRL);
      host_push = bus_wr & (sel == SEL_DATA);
      pop_req   = rd_data;
      took      = rd_data & ~empty & ~flush_q;
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_DATA:   rd_mux = took ? head_byte : last_q;
         SEL_CNT_HI: rd_mux = DATA_W'(count >> DATA_W);
         SEL_CNT_LO: rd_mux = snap_q[DATA_W-1:0];
         SEL_CTRL:   rd_mux[CTRL_KEEP_BIT] = keep_q;
         SEL_STAT:   rd_mux[STAT_OVF_BIT] = ovf_q;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_q <= 1'b0;
         keep_q  <= 1'b0;
         ovf_q   <= 1'b0;
         snap_q  <= '0;
         last_q  <= '0;
         rdata_q <= '0;
      end else begin
         flush_q <= wr_ctrl & bus_wdata[CTRL_FLUSH_BIT];
         if (wr_ctrl) keep_q <= bus_wdata[CTRL_KEEP_BIT];
         if (ovf_evt)      ovf_q <= 1'b1;
         else if (rd_stat) ovf_q <= 1'b0;
         if (rd_hi) snap_q <= count;
         if (took)  last_q <= head_byte;
         if (bus_rd) rdata_q <= rd_mux;
      end
   end

   assign bus_rdata = rdata_q;
   assign keep_old  = keep_q;
   assign flush     = flush_q;

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_q);
   // R4
   empty_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && empty) |=> (bus_rdata == $past(last_q)));
   // R10
   flush_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && !wr_ctrl) |=> !flush_q);

endmodule

// File: rtl/smpf_top.sv
module smpf_top
   import smpf_pkg::*;
#(
   parameter int DEPTH  = 512,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_strobe,
   input  logic [7:0]        smp_byte,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);

   localparam int AW   = $clog2(DEPTH);
   localparam int HI_W = CNT_W - DATA_W;

   if (DEPTH < 2) begin : g_bad_depth
      $error("smpf_top: DEPTH must be at least 2");
   end
   if (DATA_W != 8) begin : g_bad_width
      $error("smpf_top: port is byte wide, DATA_W must be 8");
   end
   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_cnt
      $error("smpf_top: CNT_W must exceed DATA_W by 1..DATA_W bits");
   end
   if (DEPTH >= (1 << CNT_W)) begin : g_cnt_small
      $error("smpf_top: CNT_W too narrow for DEPTH");
   end

   logic              keep_old, flush, host_push, pop_req;
   logic              wr_en, empty, ovf_evt, push;
   logic [AW-1:0]     waddr, raddr;
   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] head_byte, push_byte;

   // producer strobe wins over a host write in the same cycle
   assign push      = smp_strobe | host_push;
   assign push_byte = smp_strobe ? smp_byte : bus_wdata;

   smpf_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .count     (count),
      .empty     (empty),
      .head_byte (head_byte),
      .ovf_evt   (ovf_evt),
      .bus_rdata (bus_rdata),
      .keep_old  (keep_old),
      .flush     (flush),
      .host_push (host_push),
      .pop_req   (pop_req)
   );

   smpf_ptrs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .push     (push),
      .pop_req  (pop_req),
      .keep_old (keep_old),
      .wr_en    (wr_en),
      .waddr    (waddr),
      .raddr    (raddr),
      .count    (count),
      .empty    (empty),
      .ovf_evt  (ovf_evt)
   );

   smpf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .wr_en (wr_en),
      .waddr (waddr),
      .wdata (push_byte),
      .raddr (raddr),
      .rdata (head_byte)
   );

   // R8
   full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop_req && !empty && !flush) |-> !ovf_evt);
   // R2
   strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_strobe && wr_en) |-> (push_byte == smp_byte));

endmodule

// File: tb/sim_smpf_top.sv
module sim_smpf_top;

   localparam int DEPTH = 512;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strobe = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [7:0] sbyte = '0, wdata = '0;
   logic [2:0] addr = '0;
   logic [7:0] rdata;

   always #5 clk = ~clk;

   smpf_top #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_strobe(strobe), .smp_byte(sbyte),
      .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
      .bus_rdata(rdata)
   );

   int    checks = 0, errors = 0;
   bit    done = 0;
   string tag = "";
   int    q[$];
   int    last_m = 0, ovf_m = 0, snap_m = 0, mode_m = 0, fl_m = 0;

   task automatic chk(string rq, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", rq, got, exp);
      end
   endtask

   // one bus cycle: model updated from requirements, rdata checked after the edge
   task automatic step(bit s, int sb, bit w, bit r, int a, int wd);
      int    exp = 0;
      string rq = "";
      bit    old_fl, pop, psh;
      int    val;
      strobe = s; sbyte = 8'(sb); wr = w; rd = r; addr = 3'(a); wdata = 8'(wd);
      old_fl = fl_m[0];
      pop = r && a == 0 && q.size() > 0 && !old_fl;
      if (r) begin
         case (a)
            0: begin exp = pop ? q[0] : last_m; rq = pop ? "R3" : "R4"; end
            1: begin exp = q.size() >> 8; snap_m = q.size(); rq = "R9"; end
            2: begin exp = snap_m & 255; rq = "R9"; end
            3: begin exp = mode_m; rq = "R10"; end
            default: begin exp = ovf_m; ovf_m = 0; rq = "R7"; end
         endcase
      end
      if (pop) last_m = q.pop_front();
      psh = (s || (w && a == 0)) && !old_fl;
      val = s ? (sb & 255) : (wd & 255);
      if (psh) begin
         if (q.size() == DEPTH) begin
            ovf_m = 1;
            if (mode_m == 0) begin
               void'(q.pop_front());
               q.push_back(val);
            end
         end else q.push_back(val);
      end
      if (old_fl) q.delete();
      fl_m = 0;
      if (w && a == 3) begin
         mode_m = wd & 1;
         fl_m = (wd >> 1) & 1;
      end
      @(posedge clk);
      #1;
      strobe = 0; wr = 0; rd = 0;
      if (r) chk(tag != "" ? tag : rq, int'(rdata), exp);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0);
   endtask

   task automatic read_count();
      step(0, 0, 0, 1, 1, 0);
      step(0, 0, 0, 1, 2, 0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1", int'(rdata), 0);
      tag = "R1";
      read_count();
      step(0, 0, 0, 1, 4, 0);
      step(0, 0, 0, 1, 3, 0);
      tag = "";
      step(0, 0, 0, 1, 0, 0);                     // R4 empty read after reset
      // R2 producer and host pushes, collision
      step(1, 8'h31, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 8'h52);
      step(1, 8'h11, 1, 0, 0, 8'h22);
      tag = "R2";
      repeat (3) step(0, 0, 0, 1, 0, 0);
      tag = "";
      step(0, 0, 0, 1, 0, 0);                     // R4 replay last
      // R11 simultaneous push/pop mid-level
      step(1, 1, 0, 0, 0, 0);
      step(1, 2, 0, 0, 0, 0);
      step(1, 3, 0, 1, 0, 0);
      tag = "R11";
      read_count();
      tag = "";
      // R5 discard mode
      step(0, 0, 1, 0, 3, 3); idle();
      for (int i = 0; i < DEPTH + 3; i++) step(1, i, 0, 0, 0, 0);
      tag = "R5";
      read_count();
      tag = "R7";
      step(0, 0, 0, 1, 4, 0);
      step(0, 0, 0, 1, 4, 0);
      tag = "R5";
      step(0, 0, 0, 1, 0, 0);
      // R8 full, push with pop
      step(1, 8'h77, 0, 0, 0, 0);
      tag = "R8";
      step(1, 8'hAA, 0, 1, 0, 0);
      read_count();
      step(0, 0, 0, 1, 4, 0);
      // R6 overwrite mode
      step(0, 0, 1, 0, 3, 0); idle();
      step(1, 8'hC1, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 8'hC2);
      tag = "R7";
      step(0, 0, 0, 1, 4, 0);
      tag = "R6";
      step(0, 0, 0, 1, 0, 0);
      read_count();
      // R7 overflow and status read in the same cycle
      step(1, 8'hD0, 0, 0, 0, 0);
      tag = "R7";
      step(1, 8'hD1, 0, 1, 4, 0);
      step(0, 0, 0, 1, 4, 0);
      // R10 flush
      tag = "R10";
      step(0, 0, 1, 0, 3, 2); idle();
      read_count();
      step(0, 0, 0, 1, 3, 0);
      tag = "";
      step(0, 0, 0, 1, 0, 0);
      // random phases
      for (int i = 0; i < 6000; i++) begin
         int pw, op;
         pw = ((i / 700) % 2 == 0) ? 85 : 30;
         op = int'($urandom % 100);
         if (op < 1) begin
            step(0, 0, 1, 0, 3, int'($urandom % 4)); idle();
         end else if (op < 4) begin
            step(0, 0, 0, 1, 1 + int'($urandom % 4), 0);
         end else begin
            bit s, w, r;
            s = ($urandom % 100) < pw;
            w = !s && (($urandom % 8) == 0);
            r = ($urandom % 100) >= pw;
            step(s, int'($urandom % 256), w && !r, r, 0, int'($urandom % 256));
         end
      end
      read_count();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog got 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule